// File: doc/BRIEF.md
# Instruction Bundle Former

The block sits between instruction fetch and issue. It takes in a stream of 32-bit instruction words, one per handshake, each with the byte address it was fetched from. It gives out parallel-issue groups of up to four instructions. The opcode byte of each word puts it into one of four execution-unit kinds. Each kind has a fixed output slot: slot 0 for address, slot 1 for scalar, slot 2 for vector and slot 3 for branch. Consecutive words join one group as long as each new word's kind ranks strictly above every kind already in the group, and the group does not cross an aligned 16-byte quad.

A group leaves the block when a later word is known to start a new group, or when the word in the last position of a quad has been taken in. In the case where the last word of a quad itself starts a new group, the block emits the older group first. It then holds the one-word group and emits it on the next free cycle. A flush input discards a group that is still being built. Grouping then restarts from whatever address comes next. Both sides use a valid/ready handshake, and the output is a single registered stage.

Top module: `bundle_former`

## Requirements
- R1: The opcode is bits [31:24] of the word. Values 0x00-0x7f are scalar (slot 1), 0x80-0xbf are vector (slot 2), 0xc0-0xdf are address (slot 3 is not used for these: address goes to slot 0), and 0xe0-0xff are branch (slot 3). Bit i of `out_slots` marks slot i valid, and slot i's word is `out_words[32*i +: 32]`.
- R2: A word whose address bits [3:2] are zero always begins a new group. Any group open at that point is closed.
- R3: A word whose kind rank (address 0 < scalar 1 < vector 2 < branch 3) is not strictly above every rank already present in the open group closes that group and begins a new one.
- R4: Any other word joins the open group. Four words in the order address, scalar, vector, branch within one aligned quad come out as a single group with all four slots valid. No output appears before the last of them.
- R5: When the word at address bits [3:2] = 3 is accepted and joins a group, that group is valid on the outputs in the cycle after acceptance.
- R6: When an accepted word closes the open group, the closed group is valid on the outputs in the cycle after acceptance. If that word is also at quad position 3, its own one-word group follows as soon as the output register is free.
- R7: `out_addr` is the address of the first word of the group. The words of unused slots read as zero. Every emitted group has at least one slot valid.
- R8: While `flush` is high, `in_ready` is low. A group not yet closed is discarded, so the next accepted word starts a fresh group. A group already closed is still delivered.
- R9: While `out_valid` is high and `out_ready` is low, all outputs hold steady and no group is lost. Groups come out in the order in which they were closed.
- R10: During and right after synchronous reset, `out_valid` is low, no group is open, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard the group being built |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take the input word |
| in_word | input | 32 | Instruction word |
| in_addr | input | 32 | Byte address of the instruction word |
| out_valid | output | 1 | A group is presented |
| out_ready | input | 1 | Consumer takes the group |
| out_slots | output | 4 | Slot-valid bits: 0 address, 1 scalar, 2 vector, 3 branch |
| out_words | output | 128 | Slot words, slot i at bits [32*i +: 32] |
| out_addr | output | 32 | Address of the first word of the group |

## Verification
Every closed group reaches the output register at the clock edge that accepts the word closing it. It is therefore visible one cycle after that acceptance. The one exception is a held quad-end single, which appears one cycle after the output register next frees. The bench drives inputs 5 ns after a rising edge and samples on the falling edge. A word's acceptance is recorded at the falling edge before the edge that takes it, so the reference queue is always ahead of the output. The directed latency checks for R4, R5 and R6 read the outputs 5 ns after the accepting edge. The random run compares every handshaken group with the head of the reference queue, and checks that a stalled output has not changed by the next falling edge.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int NKINDS = 4;
  localparam int KIND_W = $clog2(NKINDS);
  localparam int OPC_W  = 8;

  // Rank order matters: a group only grows towards higher ranks.
  typedef enum logic [KIND_W-1:0] {
    K_ADDR = 2'd0,
    K_SCAL = 2'd1,
    K_VEC  = 2'd2,
    K_BR   = 2'd3
  } kind_e;
endpackage

// File: rtl/bf_classify.sv
module bf_classify
  import bf_pkg::*;
(
  input  logic [OPC_W-1:0]  opcode,
  output logic [KIND_W-1:0] kind
);
  kind_e k;

  always_comb begin
    casez (opcode)
      8'b0???????: k = K_SCAL;
      8'b10??????: k = K_VEC;
      8'b110?????: k = K_ADDR;
      default:     k = K_BR;
    endcase
    kind = k;
  end
endmodule

// File: rtl/bf_packer.sv
module bf_packer
  import bf_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     acc,
  input  logic [WORD_W-1:0]        word,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [KIND_W-1:0]        kind,
  input  logic                     out_free,
  output logic                     open_any,
  output logic                     emit,
  output logic [NKINDS-1:0]        e_mask,
  output logic [NKINDS*WORD_W-1:0] e_words,
  output logic [ADDR_W-1:0]        e_addr
);
  localparam int OFF_LSB = $clog2(WORD_W/8);
  localparam int OFF_W   = $clog2(NKINDS);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(NKINDS-1);

  logic [NKINDS-1:0]        mask_q, n_mask;
  logic [NKINDS*WORD_W-1:0] words_q, n_words;
  logic [ADDR_W-1:0]        base_q, n_base;
  logic                     sealed_q, n_sealed;

  logic [NKINDS-1:0]        kind_bit, at_or_above, merged_mask;
  logic [NKINDS*WORD_W-1:0] solo_w, merge_w;
  logic [OFF_W-1:0]         off;
  logic                     conflict, last;

  assign open_any    = |mask_q;
  assign off         = addr[OFF_LSB +: OFF_W];
  assign last        = (off == LAST_OFF);
  assign kind_bit    = NKINDS'(1) << kind;
  assign at_or_above = mask_q & ~(kind_bit - NKINDS'(1));
  assign merged_mask = mask_q | kind_bit;
  assign conflict    = open_any && (sealed_q || (off == '0) || (|at_or_above));

  for (genvar s = 0; s < NKINDS; s++) begin : g_slot
    assign solo_w[s*WORD_W +: WORD_W]  = (kind == KIND_W'(s)) ? word : '0;
    assign merge_w[s*WORD_W +: WORD_W] = (kind == KIND_W'(s)) ? word
                                         : words_q[s*WORD_W +: WORD_W];
  end

  always_comb begin
    emit     = 1'b0;
    e_mask   = mask_q;
    e_words  = words_q;
    e_addr   = base_q;
    n_mask   = mask_q;
    n_words  = words_q;
    n_base   = base_q;
    n_sealed = sealed_q;
    if (acc) begin
      if (conflict) begin
        emit     = 1'b1;
        n_mask   = kind_bit;
        n_words  = solo_w;
        n_base   = addr;
        n_sealed = last;
      end else if (last) begin
        emit     = 1'b1;
        e_mask   = merged_mask;
        e_words  = merge_w;
        e_addr   = open_any ? base_q : addr;
        n_mask   = '0;
        n_words  = '0;
        n_sealed = 1'b0;
      end else begin
        n_mask   = merged_mask;
        n_words  = merge_w;
        n_base   = open_any ? base_q : addr;
      end
    end else if (sealed_q && out_free) begin
      emit     = 1'b1;
      n_mask   = '0;
      n_words  = '0;
      n_sealed = 1'b0;
    end else if (flush && !sealed_q) begin
      n_mask   = '0;
      n_words  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      words_q  <= '0;
      base_q   <= '0;
      sealed_q <= 1'b0;
    end else begin
      mask_q   <= n_mask;
      words_q  <= n_words;
      base_q   <= n_base;
      sealed_q <= n_sealed;
    end
  end

  // R8
  r8_flush_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    acc |-> !flush);

  // R7
  r7_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    emit |-> (e_mask != '0));

  // R10
  r10_reset_empty_chk: assert property (@(posedge clk)
    rst |=> !open_any);
endmodule

// File: rtl/bf_out_reg.sv
module bf_out_reg #(
  parameter int NK     = 4,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 emit,
  input  logic [NK-1:0]        e_mask,
  input  logic [NK*WORD_W-1:0] e_words,
  input  logic [ADDR_W-1:0]    e_addr,
  input  logic                 out_ready,
  output logic                 out_free,
  output logic                 out_valid,
  output logic [NK-1:0]        out_slots,
  output logic [NK*WORD_W-1:0] out_words,
  output logic [ADDR_W-1:0]    out_addr
);
  assign out_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_slots <= '0;
      out_words <= '0;
      out_addr  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_slots <= e_mask;
      out_words <= e_words;
      out_addr  <= e_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9
  r9_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    emit |-> (!out_valid || out_ready));

  // R9
  r9_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slots)
                                   && $stable(out_words) && $stable(out_addr)));

  // R10
  r10_reset_chk: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: rtl/bundle_former.sv
module bundle_former
  import bf_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [WORD_W-1:0]        in_word,
  input  logic [ADDR_W-1:0]        in_addr,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NKINDS-1:0]        out_slots,
  output logic [NKINDS*WORD_W-1:0] out_words,
  output logic [ADDR_W-1:0]        out_addr
);
  localparam int OFF_LSB = $clog2(WORD_W/8);
  localparam int OFF_W   = $clog2(NKINDS);

  logic [KIND_W-1:0]        kind;
  logic                     acc, out_free, open_any, emit;
  logic [NKINDS-1:0]        e_mask;
  logic [NKINDS*WORD_W-1:0] e_words;
  logic [ADDR_W-1:0]        e_addr;
  logic [OFF_W-1:0]         off;

  assign in_ready = out_free && !flush;
  assign acc      = in_valid && in_ready;
  assign off      = in_addr[OFF_LSB +: OFF_W];

  bf_classify u_cls (
    .opcode (in_word[WORD_W-1 -: OPC_W]),
    .kind   (kind)
  );

  bf_packer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_pack (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .acc      (acc),
    .word     (in_word),
    .addr     (in_addr),
    .kind     (kind),
    .out_free (out_free),
    .open_any (open_any),
    .emit     (emit),
    .e_mask   (e_mask),
    .e_words  (e_words),
    .e_addr   (e_addr)
  );

  bf_out_reg #(.NK(NKINDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .emit      (emit),
    .e_mask    (e_mask),
    .e_words   (e_words),
    .e_addr    (e_addr),
    .out_ready (out_ready),
    .out_free  (out_free),
    .out_valid (out_valid),
    .out_slots (out_slots),
    .out_words (out_words),
    .out_addr  (out_addr)
  );

  // R2
  r2_new_bundle_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && off == '0 && open_any) |=> out_valid);

  // R5
  r5_quad_end_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && off == OFF_W'(NKINDS-1)) |=> out_valid);
endmodule

// File: tb/sim_bundle_former.sv
module sim_bundle_former;
  typedef struct packed {
    logic [3:0]   m;
    logic [127:0] w;
    logic [31:0]  a;
  } grp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_word = '0;
  logic [31:0]  in_addr = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [3:0]   out_slots;
  logic [127:0] out_words;
  logic [31:0]  out_addr;

  int   errors = 0;
  int   checks = 0;
  bit   rand_ready = 0;
  grp_t expq[$];

  // reference group under construction
  logic [3:0]   m_mask = '0;
  logic [127:0] m_words = '0;
  logic [31:0]  m_base = '0;

  grp_t log_g[64];
  int   log_n = 0;

  bit   held_v = 0;
  grp_t held;

  always #10 clk = ~clk;

  bundle_former u0 (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_slots(out_slots),
    .out_words(out_words), .out_addr(out_addr)
  );

  function automatic int rank_of(input logic [31:0] w);
    logic [7:0] op = w[31:24];
    if (op >= 8'he0) return 3;
    if (op >= 8'hc0) return 0;
    if (op >= 8'h80) return 2;
    return 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_push(input logic [3:0] m, input logic [127:0] w,
                            input logic [31:0] a);
    grp_t g;
    g.m = m; g.w = w; g.a = a;
    expq.push_back(g);
  endtask

  task automatic model_accept(input logic [31:0] w, input logic [31:0] a);
    int r = rank_of(w);
    logic [1:0] pos = a[3:2];
    bit hi_taken = 0;
    for (int i = r; i < 4; i++) if (m_mask[i]) hi_taken = 1;
    if (m_mask != 0 && (pos == 0 || hi_taken)) begin
      model_push(m_mask, m_words, m_base);
      m_mask = '0; m_words = '0;
    end
    if (m_mask == 0) m_base = a;
    m_mask[r] = 1'b1;
    m_words[r*32 +: 32] = w;
    if (pos == 3) begin
      model_push(m_mask, m_words, m_base);
      m_mask = '0; m_words = '0;
    end
  endtask

  // caller is at 5 ns after a rising edge
  task automatic send(input logic [31:0] w, input logic [31:0] a);
    bit took;
    in_valid = 1'b1; in_word = w; in_addr = a;
    forever begin
      @(negedge clk);
      took = in_ready;
      if (took) model_accept(w, a);
      @(posedge clk); #5;
      if (took) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #5; end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    #1;
    // R8
    check(in_ready == 1'b0, "R8", "in_ready during flush", 192'(in_ready), 192'(0));
    m_mask = '0; m_words = '0;
    @(posedge clk); #5;
    flush = 1'b0;
  endtask

  always @(posedge clk) begin
    #5;
    out_ready = rand_ready ? ($urandom % 4 != 0) : 1'b1;
  end

  // output monitor
  always @(negedge clk) begin
    grp_t cur, e;
    if (!rst) begin
      cur.m = out_slots; cur.w = out_words; cur.a = out_addr;
      if (held_v) begin
        // R9
        check(out_valid && cur == held, "R9", "output held under stall",
              192'({out_valid, cur}), 192'({1'b1, held}));
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(0, "R6", "unexpected group", 192'(cur), 192'(0));
        end else begin
          e = expq.pop_front();
          // R1 R2 R3 R4 R7
          check(cur == e, "R1,R3,R7", "group contents", 192'(cur), 192'(e));
        end
        if (log_n < 64) begin log_g[log_n] = cur; log_n++; end
      end
      held_v = out_valid && !out_ready;
      held   = cur;
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [31:0] mk(input int r, input int salt);
    logic [7:0] op;
    case (r)
      0: op = 8'hc5;
      1: op = 8'h12;
      2: op = 8'h9a;
      default: op = 8'he7;
    endcase
    return {op, 24'(salt * 24'h010203 + 24'h00a5)};
  endfunction

  task automatic run_pattern(input int seq[8], input logic [31:0] base,
                             input logic [3:0] exp_m[8], input int exp_n,
                             input string req);
    log_n = 0;
    for (int i = 0; i < 8; i++) send(mk(seq[i], i), base + 32'(4 * i));
    tick(4);
    check(log_n == exp_n, req, "group count", 192'(log_n), 192'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++)
      check(log_g[i].m == exp_m[i], req, "group slots",
            192'(log_g[i].m), 192'(exp_m[i]));
  endtask

  initial begin
    int seq[8];
    logic [3:0] em[8];
    logic [31:0] a;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10
    check(out_valid == 1'b0, "R10", "out_valid in reset", 192'(out_valid), 192'(0));
    check(in_ready == 1'b1, "R10", "in_ready in reset", 192'(in_ready), 192'(1));
    @(posedge clk); #1 rst = 1'b0;
    #4;
    check(out_valid == 1'b0, "R10", "out_valid after reset", 192'(out_valid), 192'(0));

    // R2: eight address words -> eight single groups
    seq = '{0,0,0,0,0,0,0,0};
    em  = '{4'b0001,4'b0001,4'b0001,4'b0001,4'b0001,4'b0001,4'b0001,4'b0001};
    run_pattern(seq, 32'h100, em, 8, "R2");

    // R3: A V S B S A V B -> |A V|S B|S|A V B|
    seq = '{0,2,1,3,1,0,2,3};
    em  = '{4'b0101,4'b1010,4'b0010,4'b1101,4'b0,4'b0,4'b0,4'b0};
    run_pattern(seq, 32'h200, em, 4, "R3");

    // R2 R6: A A A S V B B B -> |A|A|A S|V B|B|B|
    seq = '{0,0,0,1,2,3,3,3};
    em  = '{4'b0001,4'b0001,4'b0011,4'b1100,4'b1000,4'b1000,4'b0,4'b0};
    run_pattern(seq, 32'h240, em, 6, "R6");

    // R4 R5: perfect quad, one cycle after the last word
    send(mk(0, 1), 32'h300);
    send(mk(1, 2), 32'h304);
    send(mk(2, 3), 32'h308);
    check(out_valid == 1'b0, "R4", "no early group", 192'(out_valid), 192'(0));
    send(mk(3, 4), 32'h30c);
    check(out_valid && out_slots == 4'b1111, "R5", "quad end latency",
          192'({out_valid, out_slots}), 192'({1'b1, 4'b1111}));
    check(out_addr == 32'h300 && out_words[31:0] == mk(0, 1), "R7",
          "first address and slot 0 word", 192'({out_addr, out_words[31:0]}),
          192'({32'h300, mk(0, 1)}));

    // R6: closing word emits previous group one cycle later
    send(mk(2, 5), 32'h400);
    send(mk(1, 6), 32'h404);
    check(out_valid && out_slots == 4'b0100 && out_addr == 32'h400, "R6",
          "closed group latency", 192'({out_valid, out_slots, out_addr}),
          192'({1'b1, 4'b0100, 32'h400}));
    check(out_words[127:96] == 32'h0 && out_words[31:0] == 32'h0, "R7",
          "unused slot words zero", 192'({out_words[127:96], out_words[31:0]}), 192'(0));
    tick(2);
    do_flush();

    // R8: flush drops S V, then lone B at position 3
    log_n = 0;
    send(mk(1, 7), 32'h500);
    send(mk(2, 8), 32'h504);
    do_flush();
    send(mk(3, 9), 32'h50c);
    tick(3);
    check(log_n == 1, "R8", "groups after flush", 192'(log_n), 192'(1));
    check(log_g[0].m == 4'b1000 && log_g[0].a == 32'h50c, "R8", "fresh group",
          192'({log_g[0].m, log_g[0].a}), 192'({4'b1000, 32'h50c}));

    // random run with stalls
    rand_ready = 1;
    a = 32'h1000;
    for (int i = 0; i < 3000; i++) begin
      int pick = $urandom % 100;
      if (pick < 2) do_flush();
      else if (pick < 10) a = ($urandom % 32'h4000) & 32'hfffc;
      send({8'($urandom), 24'($urandom)}, a);
      a = a + 32'd4;
      if ($urandom % 8 == 0) tick(1);
    end
    do_flush();
    rand_ready = 0;
    tick(10);
    // R9: every closed group delivered, in order
    check(expq.size() == 0, "R9", "groups left undelivered", 192'(expq.size()), 192'(0));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule